// File: doc/BRIEF.md
# Message-Signalled Interrupt Concentrator

This block gathers eleven local interrupt lines and alerts a processor by sending one posted write. The write carries a data word to an address, and both come from a single target register that software programs. The block does not keep line levels as interrupts. It records changes on the lines: a rising or a falling transition of a line sets that line's capture bits. For this reason software has to poll a live level register whenever it needs level-triggered behaviour, for example after it unmasks a line that is already asserted.

A host reaches four registers and reads one more over a simple register bus: the message target, the mask, the capture (request) register, the pending register and the live levels. Reads are combinational. Reading the request register or the pending register returns its contents and clears it in the same access. A message goes out only when an enabled request bit becomes newly set. Only one message can be outstanding at a time. Events that arrive while a message waits for acceptance are merged into the request register.

Top module: `irq_msg_concentrator`

## Requirements
- R1: After reset the mask (0x018), target (0x004), request (0x00C) and pending (0x01C) registers all read zero, and `msg_valid` is low.
- R2: Reading offset 0x028 returns the current state of line n in bit n (bits 0 to 10), after two synchroniser stages. The read clears nothing.
- R3: Any transition of line n, rising or falling, sets bit n of the pending register (0x01C), whatever the mask. Bit n of the mask is 1 to enable line n.
- R4: A transition of line n sets bit n of the request register (0x00C) only when mask bit n is 1 and bit n is one of the implemented bits 0–8 and 10 (0x5FF). Bit 9 of the request register always reads zero.
- R5: A read of the request register returns and clears it, and a read of the pending register returns and clears it. Each read leaves the other register and the level register unchanged.
- R6: If a transition and a clearing read land in the same cycle, the bit stays set.
- R7: When a request bit goes from 0 to 1, the target is nonzero and no message is outstanding, `msg_valid` rises. `msg_addr` is then the target with its low 5 bits zeroed, and `msg_data` is the target's low 5 bits.
- R8: `msg_valid` and its payload stay stable until `msg_ready` is high. Events that occur while the message is held only merge into the request register and produce no second message.
- R9: While the target register is zero, no message is sent, but request bits are still captured.
- R10: A line that is already asserted when it is unmasked produces neither a request bit nor a message. Its next transition produces both.
- R11: A transition on a line whose request bit is already set produces no new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clearing reads take effect at the clock edge |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq_in | input | 11 | Raw interrupt lines |
| msg_valid | output | 1 | Message write pending |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The in-RTL assertions run on every cycle. They hold the message payload stable while it is stalled, keep bit 9 of the request register clear, check that a clearing read empties its register unless a new transition arrives, and check that a level read disturbs no capture state. The bench scenarios are the only place that shows the event-driven behaviour end to end: an asserted line being unmasked stays silent, events merge during a stall, a target of zero suppresses messages, and a set beats a clear in the same cycle. In the bench every message is matched against a queue of expected address and data pairs.

// File: rtl/irq_msg_concentrator.sv
module irq_msg_concentrator #(
  parameter int NLINES = 11,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int MSG_DATA_BITS = 5,
  parameter logic [NLINES-1:0] IMPL_MASK = 11'h5FF,
  parameter logic [ADDR_W-1:0] OFF_TARGET = 12'h004,
  parameter logic [ADDR_W-1:0] OFF_REQ = 12'h00C,
  parameter logic [ADDR_W-1:0] OFF_MASK = 12'h018,
  parameter logic [ADDR_W-1:0] OFF_PEND = 12'h01C,
  parameter logic [ADDR_W-1:0] OFF_LEVEL = 12'h028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NLINES-1:0] irq_in,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DATA_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  localparam int PAD = DATA_W - NLINES;

  logic [NLINES-1:0] sync1, sync2, prev, mask_q, req_q, pend_q;
  logic [DATA_W-1:0] target_q, msg_word;

  wire [NLINES-1:0] chg     = sync2 ^ prev;
  wire [NLINES-1:0] req_set = chg & mask_q & IMPL_MASK;
  wire rd_req  = reg_rd && (reg_addr == OFF_REQ);
  wire rd_pend = reg_rd && (reg_addr == OFF_PEND);
  wire fire    = (|(req_set & ~req_q)) && (|target_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      mask_q <= '0; req_q <= '0; pend_q <= '0;
      target_q <= '0; msg_word <= '0; msg_valid <= 1'b0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      req_q  <= (rd_req  ? '0 : req_q)  | req_set;
      pend_q <= (rd_pend ? '0 : pend_q) | chg;
      if (reg_wr && reg_addr == OFF_MASK)   mask_q   <= reg_wdata[NLINES-1:0];
      if (reg_wr && reg_addr == OFF_TARGET) target_q <= reg_wdata;
      if (msg_valid) begin
        if (msg_ready) msg_valid <= 1'b0;
      end else if (fire) begin
        msg_valid <= 1'b1;
        msg_word  <= target_q;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFF_TARGET: reg_rdata = target_q;
        OFF_REQ:    reg_rdata = {{PAD{1'b0}}, req_q};
        OFF_MASK:   reg_rdata = {{PAD{1'b0}}, mask_q};
        OFF_PEND:   reg_rdata = {{PAD{1'b0}}, pend_q};
        OFF_LEVEL:  reg_rdata = {{PAD{1'b0}}, sync2};
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign msg_addr = {msg_word[DATA_W-1:MSG_DATA_BITS], {MSG_DATA_BITS{1'b0}}};
  assign msg_data = {{(DATA_W-MSG_DATA_BITS){1'b0}}, msg_word[MSG_DATA_BITS-1:0]};

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  // R4
  unimpl_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> reg_rdata[9] == 1'b0);
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> pend_q == $past(chg));
  // R5
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> req_q == $past(req_set));
  // R2
  level_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == OFF_LEVEL |=> pend_q == $past(pend_q | chg) && req_q == $past(req_q | req_set));
  // R9
  zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (msg_addr != '0 || msg_data != '0));
endmodule

// File: tb/irq_msg_concentrator_tb.sv
module irq_msg_concentrator_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [10:0] irq_in = '0;
  logic msg_valid, msg_ready = 1;
  logic [31:0] msg_addr, msg_data;
  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  irq_msg_concentrator u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic expect_msg(logic [31:0] a, logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) chk("R7 unexpected message", {msg_addr, msg_data}, 64'h0);
      else chk("R7 message payload", {msg_addr, msg_data}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 msg_valid", {63'h0, msg_valid}, 64'h0);
    rd_chk("R1 mask", 12'h018, 0);
    rd_chk("R1 target", 12'h004, 0);
    rd_chk("R1 request", 12'h00C, 0);
    rd_chk("R1 pending", 12'h01C, 0);

    // R9: zero target, capture without message
    wr(12'h018, 32'h001);
    irq_in[0] = 1; settle();
    rd_chk("R9 request captured", 12'h00C, 32'h001);
    rd_chk("R5 request cleared", 12'h00C, 32'h000);
    rd_chk("R3 pending rise", 12'h01C, 32'h001);
    rd_chk("R5 pending cleared", 12'h01C, 32'h000);
    irq_in[0] = 0; settle();
    rd_chk("R3 pending fall", 12'h01C, 32'h001);
    rd_chk("R5 request kept after pending read", 12'h00C, 32'h001);

    // R7 messages
    wr(12'h004, 32'hF000_0023);
    rd_chk("R7 target readback", 12'h004, 32'hF000_0023);
    wr(12'h018, 32'h7FF);
    expect_msg(32'hF000_0020, 32'h3);
    irq_in[1] = 1; settle();
    rd_chk("R2 level", 12'h028, 32'h002);
    rd_chk("R2 level read leaves pending", 12'h01C, 32'h002);
    rd_chk("R4 request", 12'h00C, 32'h002);
    irq_in[9] = 1; settle();
    rd_chk("R4 bit 9 not captured", 12'h00C, 32'h000);
    rd_chk("R3 bit 9 pending", 12'h01C, 32'h200);
    expect_msg(32'hF000_0020, 32'h3);
    irq_in[1] = 0; settle();
    rd_chk("R7 falling edge request", 12'h00C, 32'h002);

    // R11
    expect_msg(32'hF000_0020, 32'h3);
    irq_in[10] = 1; settle();
    irq_in[10] = 0; settle();
    rd_chk("R11 merged request", 12'h00C, 32'h400);

    // R10
    wr(12'h018, 32'h000);
    irq_in[3] = 1; settle();
    wr(12'h018, 32'h008); settle();
    rd_chk("R10 no request on unmask", 12'h00C, 32'h000);
    rd_chk("R10 level shows line", 12'h028, 32'h208);
    expect_msg(32'hF000_0020, 32'h3);
    irq_in[3] = 0; settle();
    rd_chk("R10 next transition captured", 12'h00C, 32'h008);

    // R8 stall and merge
    wr(12'h018, 32'h030);
    msg_ready = 0;
    irq_in[4] = 1; settle();
    chk("R8 held valid", {63'h0, msg_valid}, 64'h1);
    irq_in[5] = 1; settle();
    chk("R8 still held", {63'h0, msg_valid}, 64'h1);
    chk("R8 payload stable", {msg_addr, msg_data}, {32'hF000_0020, 32'h3});
    expect_msg(32'hF000_0020, 32'h3);
    msg_ready = 1; settle();
    rd_chk("R8 merged request", 12'h00C, 32'h030);

    // R6 set beats clear
    wr(12'h018, 32'h000);
    rd(12'h01C, d);
    @(negedge clk); irq_in[6] = 1;
    @(negedge clk); @(negedge clk);
    reg_rd = 1; reg_addr = 12'h01C;
    @(negedge clk); reg_rd = 0;
    rd_chk("R6 set wins", 12'h01C, 32'h040);

    settle();
    chk("R7 all messages seen", 64'(exp_q.size()), 64'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule